// File: doc/BRIEF.md
# Word-Based PRBS Error Accumulator

This block sits behind a pseudo-random pattern checker and keeps two running totals for a link bring-up or soak test. One total counts every word the checker has judged. The other counts every judged word that held at least one mismatched bit. Each total counts in words. A word with a single bad bit and a word that is entirely wrong both add one to the error total, so software that needs bit counts must scale the results by the datapath width itself.

Software uses a byte-wide register port for control. Through it, software enables counting, holds both totals at zero, and requests a snapshot. A snapshot copies both live totals into readable shadow registers in the same clock cycle, so the pair stays consistent while it is read out one byte at a time. The control byte also shows the checker's pattern-lock flag. All read data is registered.

Top module: `prbs_word_tally`

## Requirements
- R1: After reset, the control byte reads 0 in bits 2:0, and every count byte reads 0.
- R2: The control byte at address 0x300 holds three read/write bits: enable in bit 0, clear in bit 1 and snapshot in bit 2. These bits read back the value last written. Bit 3 reads the current `chk_locked` input, and writes to it are ignored. Bits 7:4 read 0.
- R3: While enable is 1 and clear is 0, the word total rises by one for each cycle in which `word_vld` is 1. It does not change when `word_vld` is 0 or when enable is 0.
- R4: Under the same conditions, the error total rises by exactly one for each cycle in which `word_vld` and `word_err` are both 1. `word_err` has no effect when `word_vld` is 0.
- R5: While clear is 1, both totals are held at zero, and clear wins over a word arriving in the same cycle. Counting resumes once clear is written back to 0.
- R6: On each clock edge at which snapshot is 1, both shadow registers take the live totals together. While snapshot is 0, the shadows keep their value, whatever the counting does.
- R7: The error shadow reads at 0x301 to 0x307 and the word shadow at 0x30D to 0x313. In both, the least significant byte is at the lowest address. Bits above bit 49, which are the upper six bits of the top byte, read 0.
- R8: Each total stops at all-ones rather than wrapping.
- R9: Reads of any other address return 0. Writes to count or unmapped addresses change nothing.
- R10: `reg_rdata` shows the addressed byte after the clock edge at which `reg_rd` was 1. After an edge with `reg_rd` at 0, it shows 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised on release |
| word_vld | input | 1 | Checker has judged a word this cycle |
| word_err | input | 1 | The judged word had at least one mismatched bit |
| chk_locked | input | 1 | Checker has locked onto the pattern and completed a first pass |
| reg_addr | input | 10 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |

## Verification
The bench raises `word_err` on idle cycles between words. A design that counted errors without gating on valid would report more errors than words. It also sends words while clear is set, and then while counting is disabled. A design that let counting win over clear, or ignored the enable, would show non-zero or inflated totals. The snapshot is frozen while words keep arriving, and both shadows are then compared. A design that refreshed the shadows without a request, or loaded only one of them, would fail that comparison. A second instance with 3-bit counters is driven past its limit to catch wrapping. Totals above 255 catch swapped byte order.

// File: rtl/prbs_tally_pkg.sv
package prbs_tally_pkg;

  typedef struct packed {
    logic snap;
    logic clr;
    logic en;
  } ctrl_t;

  localparam int IDX_PASS = 0;
  localparam int IDX_ERR  = 1;
  localparam int N_CNT    = 2;

  function automatic int bytes_for(input int bits);
    return (bits + 7) / 8;
  endfunction

endpackage

// File: rtl/tally_sat_cnt.sv
module tally_sat_cnt #(
  parameter int W = 50
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] q_nxt;
  logic         q_en;

  always_comb begin
    q_en  = clr | inc;
    q_nxt = q;
    if (clr)
      q_nxt = '0;
    else if (inc && (q != MAX))
      q_nxt = q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= '0;
    else if (q_en)
      q <= q_nxt;
  end

  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (q == MAX && inc && !clr) |=> (q == MAX));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && q != MAX) |=> (q == $past(q) + W'(1)));

  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(q));

endmodule

// File: rtl/tally_regs.sv
module tally_regs
  import prbs_tally_pkg::*;
#(
  parameter int               CNT_W     = 50,
  parameter int               ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 10'h300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              done,
  input  logic [CNT_W-1:0]  live_pass,
  input  logic [CNT_W-1:0]  live_err,
  output ctrl_t             ctrl
);

  localparam int                NBYTES    = bytes_for(CNT_W);
  localparam logic [ADDR_W-1:0] ERR_BASE  = CTRL_ADDR + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] PASS_BASE = CTRL_ADDR + ADDR_W'(13);

  ctrl_t             ctrl_nxt;
  logic [CNT_W-1:0]  shd_pass, shd_err;
  logic [NBYTES*8-1:0] pad_pass, pad_err;
  logic [7:0]        rd_nxt;
  logic              wr_ctrl;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata[7:3];
  assign wr_ctrl      = reg_wr && (reg_addr == CTRL_ADDR);

  always_comb begin
    ctrl_nxt = ctrl;
    if (wr_ctrl)
      ctrl_nxt = ctrl_t'(reg_wdata[2:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl <= '0;
    else if (wr_ctrl)
      ctrl <= ctrl_nxt;
  end

  // Both shadows share one enable so the pair is captured in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_pass <= '0;
      shd_err  <= '0;
    end else if (ctrl.snap) begin
      shd_pass <= live_pass;
      shd_err  <= live_err;
    end
  end

  always_comb begin
    pad_pass = '0;
    pad_err  = '0;
    pad_pass[CNT_W-1:0] = shd_pass;
    pad_err[CNT_W-1:0]  = shd_err;
    rd_nxt = '0;
    if (reg_rd) begin
      if (reg_addr == CTRL_ADDR)
        rd_nxt = {4'b0, done, ctrl};
      for (int b = 0; b < NBYTES; b++) begin
        if (reg_addr == ERR_BASE + ADDR_W'(b))
          rd_nxt = pad_err[b*8 +: 8];
        if (reg_addr == PASS_BASE + ADDR_W'(b))
          rd_nxt = pad_pass[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      reg_rdata <= '0;
    else
      reg_rdata <= rd_nxt;
  end

  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl));

  a_r6_snap_pair: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.snap |=> (shd_pass == $past(live_pass) && shd_err == $past(live_err)));

  a_r6_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.snap |=> ($stable(shd_pass) && $stable(shd_err)));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> (reg_rdata == 8'h00));

endmodule

// File: rtl/prbs_word_tally.sv
module prbs_word_tally
  import prbs_tally_pkg::*;
#(
  parameter int               CNT_W     = 50,
  parameter int               ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 10'h300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  logic              word_err,
  input  logic              chk_locked,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata
);

  logic             rst_meta, rst_sync_n;
  ctrl_t            ctrl;
  logic [N_CNT-1:0] inc_vec;
  logic [CNT_W-1:0] cnt_q [N_CNT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    inc_vec[IDX_PASS] = ctrl.en & word_vld;
    inc_vec[IDX_ERR]  = ctrl.en & word_vld & word_err;
  end

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    tally_sat_cnt #(.W(CNT_W)) i_cnt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .clr   (ctrl.clr),
      .inc   (inc_vec[g]),
      .q     (cnt_q[g])
    );
  end

  tally_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) i_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .done      (chk_locked),
    .live_pass (cnt_q[IDX_PASS]),
    .live_err  (cnt_q[IDX_ERR]),
    .ctrl      (ctrl)
  );

  a_r4_err_le_pass: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cnt_q[IDX_ERR] <= cnt_q[IDX_PASS]);

  a_r4_no_err_without_vld: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!word_vld && !ctrl.clr) |=> $stable(cnt_q[IDX_ERR]));

endmodule

// File: tb/test_prbs_word_tally.sv
`timescale 1ns/1ps
module test_prbs_word_tally;

  localparam logic [9:0] A_CTRL = 10'h300;
  localparam logic [9:0] A_ERR  = 10'h301;
  localparam logic [9:0] A_PASS = 10'h30D;

  typedef struct packed {
    bit          en;
    int unsigned nw;
    int unsigned ne;
    int unsigned xp;
    int unsigned xe;
  } vec_t;

  // enable, words, errored words, expected word total, expected error total
  localparam vec_t VEC [5] = '{
    '{1'b1, 5, 2, 5, 2},
    '{1'b1, 3, 0, 8, 2},
    '{1'b0, 4, 4, 8, 2},
    '{1'b1, 6, 6, 14, 8},
    '{1'b1, 0, 0, 14, 8}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       word_vld = 1'b0, word_err = 1'b0, chk_locked = 1'b0;
  logic [9:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata, s_rdata;
  int         total = 0, bad = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  prbs_word_tally i_prbs_word_tally (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_err(word_err),
    .chk_locked(chk_locked), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  prbs_word_tally #(.CNT_W(3)) i_prbs_word_tally_sat (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_err(word_err),
    .chk_locked(chk_locked), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(s_rdata));

  task automatic check(input string req, input logic [55:0] act, input logic [55:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [7:0] d, output logic [7:0] sd);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata; sd = s_rdata;
  endtask

  task automatic rd_cnt(input logic [9:0] base, output logic [55:0] v, output logic [55:0] sv);
    logic [7:0] d, sd;
    v = '0; sv = '0;
    for (int b = 0; b < 7; b++) begin
      rd(base + 10'(b), d, sd);
      v[b*8 +: 8] = d;
      if (b == 0) sv = {48'b0, sd};
    end
  endtask

  // Words separated by idle cycles that carry word_err high.
  task automatic send(input int unsigned nw, input int unsigned ne);
    for (int unsigned i = 0; i < nw; i++) begin
      @(negedge clk);
      word_vld = 1'b1; word_err = (i < ne);
      @(negedge clk);
      word_vld = 1'b0; word_err = 1'b1;
    end
    @(negedge clk);
    word_err = 1'b0;
  endtask

  task automatic snapshot(input bit en);
    wr(A_CTRL, {5'b0, 1'b1, 1'b0, en});
    wr(A_CTRL, {7'b0, en});
  endtask

  function automatic logic [55:0] sat7(input int unsigned v);
    return (v > 7) ? 56'd7 : 56'(v);
  endfunction

  task automatic check_totals(input string tag, input int unsigned xp, input int unsigned xe);
    logic [55:0] v, sv;
    rd_cnt(A_ERR, v, sv);
    check({tag, " err total"}, v, 56'(xe));
    check("R8 small err saturates", sv, sat7(xe));
    rd_cnt(A_PASS, v, sv);
    check({tag, " word total"}, v, 56'(xp));
    check("R8 small word saturates", sv, sat7(xp));
  endtask

  initial begin
    #(5ns * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d, sd;
    logic [55:0] v, sv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_CTRL, d, sd);
    check("R1 ctrl after reset", 56'(d), 56'h0);
    rd_cnt(A_ERR, v, sv);
    check("R1 err bytes after reset", v, 56'h0);
    rd_cnt(A_PASS, v, sv);
    check("R1 word bytes after reset", v, 56'h0);

    // R2 read-back, lock bit, ignored upper bits
    wr(A_CTRL, 8'hFF);
    rd(A_CTRL, d, sd);
    check("R2 ctrl readback lock=0", 56'(d), 56'h07);
    chk_locked = 1'b1;
    wr(A_CTRL, 8'h02);
    rd(A_CTRL, d, sd);
    check("R2 ctrl readback lock=1", 56'(d), 56'h0A);
    wr(A_CTRL, 8'h00);

    // R10 registered data then zero
    rd(A_CTRL, d, sd);
    check("R10 read data", 56'(d), 56'h08);
    @(negedge clk);
    check("R10 idle read data zero", 56'(reg_rdata), 56'h0);

    // Vector table: R3 R4 R8
    foreach (VEC[k]) begin
      wr(A_CTRL, {7'b0, VEC[k].en});
      send(VEC[k].nw, VEC[k].ne);
      snapshot(VEC[k].en);
      check_totals("R3/R4 vector", VEC[k].xp, VEC[k].xe);
    end

    // R5 clear holds zero while words arrive, then resumes
    wr(A_CTRL, 8'h03);
    send(3, 3);
    snapshot(1'b1);
    check_totals("R5 cleared", 0, 0);
    send(2, 1);
    snapshot(1'b1);
    check_totals("R5 resume", 2, 1);

    // R6 freeze and re-snapshot
    send(3, 0);
    snapshot(1'b1);
    send(4, 4);
    check_totals("R6 frozen", 5, 1);
    snapshot(1'b1);
    check_totals("R6 refreshed", 9, 5);

    // R7 byte order above 255
    send(300, 300);
    snapshot(1'b1);
    check_totals("R7 multibyte", 309, 305);
    rd(A_ERR + 10'd1, d, sd);
    check("R7 err byte1 at 0x302", 56'(d), 56'h01);
    rd(A_PASS + 10'd1, d, sd);
    check("R7 word byte1 at 0x30E", 56'(d), 56'h01);
    rd(A_PASS, d, sd);
    check("R7 word byte0 at 0x30D", 56'(d), 56'h35);
    rd(A_ERR + 10'd6, d, sd);
    check("R7 top byte upper bits zero", 56'(d), 56'h00);

    // R9 unmapped reads and ignored writes
    rd(10'h308, d, sd);
    check("R9 unmapped 0x308", 56'(d), 56'h0);
    rd(10'h30C, d, sd);
    check("R9 unmapped 0x30C", 56'(d), 56'h0);
    rd(10'h314, d, sd);
    check("R9 unmapped 0x314", 56'(d), 56'h0);
    wr(A_ERR, 8'hAA);
    wr(10'h308, 8'h55);
    rd(A_ERR, d, sd);
    check("R9 write to count ignored", 56'(d), 56'h31);
    rd(A_CTRL, d, sd);
    check("R9 ctrl untouched by other writes", 56'(d), 56'h09);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule